// File: doc/BRIEF.md
# Short I/O Configuration Port Decoder

This block is the slave-side decoder for a 1 KB window in the 16-bit short I/O address space. Address bits 15..10 are compared against a six-position base switch. The address modifier code then qualifies the access. Only the supervisory short I/O code is accepted, or the non-privileged code as well, depending on a privilege select input.

Once an access is decoded, it is routed by byte parity:

- **Odd byte addresses** go to a 16-register clock peripheral on data bits 7..0. The register index is taken from address bits 4..1, so the register set repeats every 32 bytes across the window.
- **Even byte addresses** read back a constant configuration byte on data bits 15..8. This byte describes the memory type and device size of two banks.

A decoded access is acknowledged one clock after the strobe. The acknowledge drops as soon as the strobe is removed.

Top module: `sio_cfg_decoder`

## Requirements
- R1: An access decodes only when addr_i[15:10] equals base_sw_i bit for bit, where a switch value of 1 (open) matches an address bit of 1 and 0 (closed) matches 0.
- R2: With priv_any_i = 1, modifiers 6'h29 and 6'h2D are accepted. With priv_any_i = 0, only 6'h2D is accepted.
- R3: A strobe whose address or modifier does not match raises neither clk_sel_o, clk_we_o nor ack_o, and rdata_o stays 16'h0000.
- R4: A decoded access with addr_i[0] = 1 raises clk_sel_o with clk_idx_o = addr_i[4:1] for as long as the strobe lasts, so the register set repeats every 32 bytes.
- R5: A decoded odd write gives exactly one clk_we_o pulse, in the first strobe cycle, with clk_wdata_o equal to wdata_i.
- R6: A decoded odd read returns {8'h00, peripheral byte} on rdata_o while acknowledged. The peripheral byte is sampled in the first strobe cycle and stays stable.
- R7: A decoded even read returns {b1_type, b1_size, b2_type, b2_size} in rdata_o[15:8] with rdata_o[7:0] = 0. The type codes are 00 EPROM, 01 SRAM and 10 FLASH/EEPROM. The size codes are 00/01/10/11 for 128K/256K/512K/1024K by 8.
- R8: A decoded even write is acknowledged, returns rdata_o = 0, and raises neither clk_sel_o nor clk_we_o.
- R9: ack_o rises at the first clock edge after a decoded strobe, holds while the strobe holds, and falls in the same cycle the strobe is removed.
- R10: During reset, ack_o and rdata_o are 0 even when a matching strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Access strobe from the bus side |
| addr_i | input | 16 | Short I/O byte address |
| am_i | input | 6 | Address modifier code |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data, low data lane |
| base_sw_i | input | 6 | Base switch setting for address bits 15..10 |
| priv_any_i | input | 1 | 1 = accept non-privileged or supervisory, 0 = supervisory only |
| b1_type_i | input | 2 | Bank 1 memory type code |
| b1_size_i | input | 2 | Bank 1 device size code |
| b2_type_i | input | 2 | Bank 2 memory type code |
| b2_size_i | input | 2 | Bank 2 device size code |
| clk_rdata_i | input | 8 | Read byte from the clock peripheral |
| clk_sel_o | output | 1 | Clock peripheral select |
| clk_idx_o | output | 4 | Clock peripheral register index |
| clk_we_o | output | 1 | Clock peripheral write pulse |
| clk_wdata_o | output | 8 | Clock peripheral write byte |
| rdata_o | output | 16 | Read data returned to the bus side |
| ack_o | output | 1 | Acknowledge |

## Verification
Some properties are checked on every cycle by the assertions:

- a decoded strobe is followed by an acknowledge;
- a miss never selects the peripheral;
- an even-byte access never selects the peripheral;
- the write pulse lasts a single cycle;
- read data is stable while acknowledged.

Other behaviour can only be shown by the bench's scenarios. This covers the values themselves: which base and modifier combinations decode, the register index mirroring at window edges, and the packed configuration byte for different bank settings. It also covers the ordering of acknowledge rise and fall against strobe changes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [5:0] AM_SIO_SUPER = 6'h2D;
   localparam logic [5:0] AM_SIO_USER  = 6'h29;

   typedef enum logic [1:0] {
      MT_EPROM = 2'b00,
      MT_SRAM  = 2'b01,
      MT_FLASH = 2'b10
   } mem_type_e;

   typedef struct packed {
      logic [1:0] b1_type;
      logic [1:0] b1_size;
      logic [1:0] b2_type;
      logic [1:0] b2_size;
   } cfg_byte_t;

   function automatic logic [7:0] pack_cfg(input logic [1:0] t1, input logic [1:0] s1,
                                           input logic [1:0] t2, input logic [1:0] s2);
      cfg_byte_t c;
      c.b1_type = t1;
      c.b1_size = s1;
      c.b2_type = t2;
      c.b2_size = s2;
      return c;
   endfunction
endpackage

// File: rtl/sio_window_match.sv
module sio_window_match #(
   parameter int BASE_W    = 6,
   parameter int AM_W      = 6,
   parameter bit AM_FILTER = 1'b1
) (
   input  logic              strobe_i,
   input  logic [BASE_W-1:0] addr_hi_i,
   input  logic [BASE_W-1:0] base_sw_i,
   input  logic [AM_W-1:0]   am_i,
   input  logic              priv_any_i,
   output logic              hit_o
);
   import sio_cfg_pkg::*;

   logic [BASE_W-1:0] bit_eq;
   logic              am_ok;

   if (BASE_W < 1) begin : g_bad_base
      $error("sio_window_match: BASE_W must be at least 1");
   end
   if (AM_W != 6) begin : g_bad_am
      $error("sio_window_match: AM_W must be 6");
   end

   for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
      assign bit_eq[i] = ~(addr_hi_i[i] ^ base_sw_i[i]);
   end

   if (AM_FILTER) begin : g_am_filter
      always_comb begin
         am_ok = (am_i == AM_SIO_SUPER) || (priv_any_i && (am_i == AM_SIO_USER));
      end
   end else begin : g_am_open
      logic unused_am;
      assign unused_am = ^{am_i, priv_any_i};
      assign am_ok = 1'b1;
   end

   assign hit_o = strobe_i && (&bit_eq) && am_ok;
endmodule

// File: rtl/sio_lane_router.sv
module sio_lane_router #(
   parameter int IDX_W  = 4,
   parameter int BYTE_W = 8
) (
   input  logic              hit_i,
   input  logic              first_i,
   input  logic              odd_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              write_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic [BYTE_W-1:0] cfg_byte_i,
   input  logic [BYTE_W-1:0] clk_rdata_i,
   output logic              clk_sel_o,
   output logic [IDX_W-1:0]  clk_idx_o,
   output logic              clk_we_o,
   output logic [BYTE_W-1:0] clk_wdata_o,
   output logic [2*BYTE_W-1:0] lane_data_o
);
   localparam logic [BYTE_W-1:0] ZERO_B = '0;

   if (IDX_W < 1) begin : g_bad_idx
      $error("sio_lane_router: IDX_W must be at least 1");
   end

   assign clk_sel_o   = hit_i && odd_i;
   assign clk_idx_o   = idx_i;
   assign clk_we_o    = hit_i && odd_i && write_i && first_i;
   assign clk_wdata_o = wdata_i;

   always_comb begin
      lane_data_o = '0;
      if (!write_i) begin
         if (odd_i) lane_data_o = {ZERO_B, clk_rdata_i};
         else       lane_data_o = {cfg_byte_i, ZERO_B};
      end
   end
endmodule

// File: rtl/sio_ack_ctrl.sv
module sio_ack_ctrl #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic              hit_i,
   input  logic [DATA_W-1:0] lane_data_i,
   output logic              first_o,
   output logic              ack_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic              ack_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         data_q <= '0;
      end else begin
         ack_q <= hit_i;
         if (hit_i && !ack_q) data_q <= lane_data_i;
         else if (!hit_i)     data_q <= '0;
      end
   end

   assign first_o = hit_i && !ack_q;
   assign ack_o   = ack_q && strobe_i;
   assign rdata_o = ack_o ? data_q : '0;

   p_ack_follows_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (ack_o || !strobe_i));
   p_rdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && $past(ack_o)) |-> $stable(rdata_o));
endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder #(
   parameter int ADDR_W    = 16,
   parameter int WIN_W     = 10,
   parameter int IDX_W     = 4,
   parameter int AM_W      = 6,
   parameter bit AM_FILTER = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    strobe_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [AM_W-1:0]         am_i,
   input  logic                    write_i,
   input  logic [7:0]              wdata_i,
   input  logic [ADDR_W-WIN_W-1:0] base_sw_i,
   input  logic                    priv_any_i,
   input  logic [1:0]              b1_type_i,
   input  logic [1:0]              b1_size_i,
   input  logic [1:0]              b2_type_i,
   input  logic [1:0]              b2_size_i,
   input  logic [7:0]              clk_rdata_i,
   output logic                    clk_sel_o,
   output logic [IDX_W-1:0]        clk_idx_o,
   output logic                    clk_we_o,
   output logic [7:0]              clk_wdata_o,
   output logic [15:0]             rdata_o,
   output logic                    ack_o
);
   import sio_cfg_pkg::*;

   localparam int BASE_W = ADDR_W - WIN_W;
   localparam int BYTE_W = 8;
   localparam int DATA_W = 2 * BYTE_W;

   if (WIN_W < IDX_W + 2) begin : g_bad_win
      $error("sio_cfg_decoder: window too small for register index");
   end
   if (BASE_W < 1) begin : g_bad_addr
      $error("sio_cfg_decoder: ADDR_W must exceed WIN_W");
   end

   logic              hit;
   logic              first;
   logic [DATA_W-1:0] lane_data;
   logic [7:0]        cfg_byte;
   logic              unused_mid_addr;

   assign unused_mid_addr = ^addr_i[WIN_W-1:IDX_W+1];
   assign cfg_byte = pack_cfg(b1_type_i, b1_size_i, b2_type_i, b2_size_i);

   sio_window_match #(.BASE_W(BASE_W), .AM_W(AM_W), .AM_FILTER(AM_FILTER)) u_match (
      .strobe_i   (strobe_i),
      .addr_hi_i  (addr_i[ADDR_W-1:WIN_W]),
      .base_sw_i  (base_sw_i),
      .am_i       (am_i),
      .priv_any_i (priv_any_i),
      .hit_o      (hit)
   );

   sio_lane_router #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_route (
      .hit_i       (hit),
      .first_i     (first),
      .odd_i       (addr_i[0]),
      .idx_i       (addr_i[IDX_W:1]),
      .write_i     (write_i),
      .wdata_i     (wdata_i),
      .cfg_byte_i  (cfg_byte),
      .clk_rdata_i (clk_rdata_i),
      .clk_sel_o   (clk_sel_o),
      .clk_idx_o   (clk_idx_o),
      .clk_we_o    (clk_we_o),
      .clk_wdata_o (clk_wdata_o),
      .lane_data_o (lane_data)
   );

   sio_ack_ctrl #(.DATA_W(DATA_W)) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_i    (strobe_i),
      .hit_i       (hit),
      .lane_data_i (lane_data),
      .first_o     (first),
      .ack_o       (ack_o),
      .rdata_o     (rdata_o)
   );

   p_miss_no_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (!clk_sel_o && !clk_we_o));
   p_even_no_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !addr_i[0]) |-> !clk_sel_o);
   p_single_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_we_o |=> !clk_we_o);
endmodule

// File: tb/sio_cfg_decoder_tb.sv
`timescale 1ns/1ps
module sio_cfg_decoder_tb;
   typedef struct packed {
      logic [15:0] addr;
      logic [5:0]  am;
      logic        wr;
      logic [5:0]  base;
      logic        priv;
      logic        hit;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'h8C03, 6'h2D, 1'b0, 6'h23, 1'b0, 1'b1},
      '{16'h8C22, 6'h2D, 1'b0, 6'h23, 1'b0, 1'b1},
      '{16'h8FE3, 6'h29, 1'b0, 6'h23, 1'b1, 1'b1},
      '{16'h8C03, 6'h29, 1'b0, 6'h23, 1'b0, 1'b0},
      '{16'h9003, 6'h2D, 1'b0, 6'h23, 1'b1, 1'b0},
      '{16'h0001, 6'h2D, 1'b1, 6'h00, 1'b1, 1'b1},
      '{16'hFC1F, 6'h29, 1'b0, 6'h3F, 1'b1, 1'b1},
      '{16'hFC10, 6'h2D, 1'b1, 6'h3F, 1'b0, 1'b1},
      '{16'h8C05, 6'h3D, 1'b0, 6'h23, 1'b1, 1'b0},
      '{16'h7C1E, 6'h2D, 1'b0, 6'h1F, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0;
   logic [15:0] addr = '0;
   logic [5:0] am = '0;
   logic wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [5:0] base = '0;
   logic priv = 1'b0;
   logic [1:0] t1 = 2'b01, s1 = 2'b10, t2 = 2'b10, s2 = 2'b11;
   logic [7:0] prd;
   logic clk_sel, clk_we, ack;
   logic [3:0] clk_idx;
   logic [7:0] clk_wdata;
   logic [15:0] rdata;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;
   assign prd = {4'hA, clk_idx};

   sio_cfg_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .addr_i(addr), .am_i(am),
      .write_i(wr), .wdata_i(wdata), .base_sw_i(base), .priv_any_i(priv),
      .b1_type_i(t1), .b1_size_i(s1), .b2_type_i(t2), .b2_size_i(s2),
      .clk_rdata_i(prd), .clk_sel_o(clk_sel), .clk_idx_o(clk_idx),
      .clk_we_o(clk_we), .clk_wdata_o(clk_wdata), .rdata_o(rdata), .ack_o(ack));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input vec_t v, input logic [7:0] wd);
      logic odd;
      logic [15:0] exp_rd;
      odd = v.addr[0];
      if (!v.hit || v.wr) exp_rd = 16'h0000;
      else if (odd)       exp_rd = {8'h00, 4'hA, v.addr[4:1]};
      else                exp_rd = {t1, s1, t2, s2, 8'h00};
      @(negedge clk);
      addr = v.addr; am = v.am; wr = v.wr; base = v.base; priv = v.priv; wdata = wd;
      strobe = 1'b1;
      #1;
      chk("R1/R2/R4 clk_sel", {15'b0, clk_sel}, {15'b0, v.hit & odd});
      if (v.hit && odd) chk("R4 clk_idx", {12'b0, clk_idx}, {12'b0, v.addr[4:1]});
      chk("R3/R5/R8 clk_we first", {15'b0, clk_we}, {15'b0, v.hit & odd & v.wr});
      if (v.hit && odd && v.wr) chk("R5 clk_wdata", {8'b0, clk_wdata}, {8'b0, wd});
      chk("R9 ack before edge", {15'b0, ack}, 16'h0);
      @(negedge clk);
      chk("R9/R3 ack after edge", {15'b0, ack}, {15'b0, v.hit});
      chk("R6/R7/R8/R3 rdata", rdata, exp_rd);
      chk("R5 clk_we single", {15'b0, clk_we}, 16'h0);
      @(negedge clk);
      chk("R6 rdata held", rdata, exp_rd);
      strobe = 1'b0;
      #1;
      chk("R9 ack release", {15'b0, ack}, 16'h0);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R10: matching strobe held during reset
      @(negedge clk);
      addr = 16'h8C03; am = 6'h2D; base = 6'h23; strobe = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 ack in reset", {15'b0, ack}, 16'h0);
      chk("R10 rdata in reset", rdata, 16'h0);
      strobe = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) access(VECS[i], 8'hC4 + 8'(i));

      // R7: different bank codes
      t1 = 2'b00; s1 = 2'b00; t2 = 2'b00; s2 = 2'b01;
      access('{16'h4402, 6'h2D, 1'b0, 6'h11, 1'b0, 1'b1}, 8'h00);
      chk("R7 packed byte", rdata, 16'h0000);
      // R1: every base bit sensitive - flip each bit of the address
      for (int b = 10; b < 16; b++)
         access('{16'hAAA1 ^ (16'h1 << b), 6'h2D, 1'b0, 6'h2A, 1'b0, 1'b0}, 8'h00);
      access('{16'hAAA1, 6'h2D, 1'b0, 6'h2A, 1'b0, 1'b1}, 8'h00);

      // R9: strobe drop and immediate restart gives no ack on first cycle
      @(negedge clk);
      addr = 16'h8C07; am = 6'h2D; base = 6'h23; wr = 1'b0; strobe = 1'b1;
      @(negedge clk);
      chk("R9 ack held", {15'b0, ack}, 16'h1);
      strobe = 1'b0;
      #1 chk("R9 ack drops with strobe", {15'b0, ack}, 16'h0);
      @(negedge clk);
      strobe = 1'b1;
      #1 chk("R9 no early ack on restart", {15'b0, ack}, 16'h0);
      @(negedge clk);
      chk("R9 ack on restart", {15'b0, ack}, 16'h1);
      chk("R6 odd index 3", rdata, 16'h00A3);
      strobe = 1'b0;
      repeat (2) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule